// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence

This block watches the stream of finished channel-0 light conversions. Each time a result strobe arrives, the 16-bit count is compared against a programmable low and high limit. Results that fall outside the window are counted as a run of consecutive hits. When the run reaches the length selected by a 4-bit persistence code, the block sets a sticky interrupt flag.

The flag can always be read on the status output. The active-low interrupt line follows the flag only while the enable input is high. The flag stays set until a one-cycle clear pulse arrives. A clear also restarts the run counter.

Persistence code zero is a special case. With code zero, every completed conversion raises the flag, whatever its value.

Top module: `window_irq_persist`

## Requirements
- R1: A result counts as outside the window only when its unsigned value is strictly below the low limit or strictly above the high limit. A value equal to either limit is inside.
- R2: With persistence code 0, every strobed result sets the flag in the cycle after its strobe, whether it is inside or outside the window.
- R3: Codes 1, 2 and 3 set the flag after exactly 1, 2 and 3 consecutive outside results.
- R4: Codes 4 to 15 set the flag after exactly 5×(code−3) consecutive outside results, that is 5, 10, …, 60.
- R5: A strobed inside result resets the run to zero, so the full run length must then be seen again.
- R6: Once set, the status flag stays high until a clear pulse. The flag is low in the cycle after the clear.
- R7: `irq_n` is low exactly when the status flag is high and `irq_en` is 1. The status flag does not depend on `irq_en`.
- R8: While `res_vld` is 0, the data and limit inputs neither set the flag nor advance the run.
- R9: A clear in the same cycle as a qualifying result wins: the flag is low afterwards and the run restarts from zero.
- R10: After reset the status flag is 0, `irq_n` is 1 and the run is empty.
- R11: The run counter saturates at the selected target and never exceeds it. A long outside stream therefore keeps the flag set and does not wrap the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | One-cycle strobe: a conversion result is present |
| res_cnt | input | 16 | Channel-0 conversion count |
| lim_lo | input | 16 | Low window limit |
| lim_hi | input | 16 | High window limit |
| pers_code | input | 4 | Persistence code |
| irq_en | input | 1 | Output enable for the interrupt line |
| irq_clr | input | 1 | One-cycle clear of the flag and the run |
| irq_status | output | 1 | Sticky interrupt flag |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
Two events can land in the same cycle: a clear pulse and a result that would complete the run. The bench drives both on one edge. It then checks that the flag reads low, and that the following results need a full run again counted from zero. The sweep also covers every persistence code at run lengths one short of the target and exactly at the target. It probes the window edges at each limit and one count on either side, and it toggles the enable while the flag is held.

// File: rtl/win_irq_pkg.sv
package win_irq_pkg;

   // Required run length for a persistence code.
   // Codes up to lin_codes map linearly; later codes step by step_sz.
   function automatic int unsigned run_len(int unsigned code,
                                           int unsigned lin_codes,
                                           int unsigned step_sz);
      if (code <= lin_codes) return code;
      return (code - lin_codes) * step_sz;
   endfunction

endpackage

// File: rtl/window_cmp.sv
module window_cmp #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   output logic              outside
);
   logic below, above;

   // Strict, unsigned comparisons: equality counts as inside.
   always_comb begin
      below   = value < lo;
      above   = value > hi;
      outside = below | above;
   end
endmodule

// File: rtl/persist_ctr.sv
module persist_ctr #(
   parameter int CODE_W    = 4,
   parameter int LIN_CODES = 3,
   parameter int STEP_SZ   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_vld,
   input  logic              outside,
   input  logic              clr,
   input  logic [CODE_W-1:0] code,
   output logic              fire
);
   import win_irq_pkg::*;

   localparam int NCODES  = 2 ** CODE_W;
   localparam int MAX_RUN = run_len(NCODES - 1, LIN_CODES, STEP_SZ);
   localparam int CNT_W   = $clog2(MAX_RUN + 1);

   initial begin
      param_chk : assert (LIN_CODES < NCODES && STEP_SZ > 0 && CODE_W > 0)
         else $error("persist_ctr: bad parameters");
   end

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] target;
   logic [CNT_W:0]   run_inc;
   logic [CNT_W-1:0] run_sat;
   logic             code_zero;

   // Target lookup, built from the package function per code.
   logic [CNT_W-1:0] tgt_tab [NCODES];
   for (genvar g = 0; g < NCODES; g++) begin : g_tab
      assign tgt_tab[g] = CNT_W'(run_len(g, LIN_CODES, STEP_SZ));
   end

   always_comb begin
      target    = tgt_tab[code];
      code_zero = (code == '0);
      run_inc   = {1'b0, run_q} + 1'b1;
      // Clamp to the target so the counter never wraps.
      run_sat   = (run_inc >= {1'b0, target}) ? target : run_inc[CNT_W-1:0];
      fire      = res_vld & ~clr &
                  (code_zero | (outside & (run_inc >= {1'b0, target})));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run_q <= '0;
      else if (clr)                  run_q <= '0;
      else if (res_vld && !outside)  run_q <= '0;
      else if (res_vld)              run_q <= run_sat;
   end

   // R11
   run_bound_chk : assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CNT_W'(MAX_RUN));

   // R5
   inside_reset_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !outside && !clr) |=> (run_q == '0));

   // R9
   clr_restart_chk : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (run_q == '0));

   // R8
   idle_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!res_vld && !clr) |=> $stable(run_q));
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic status,
   output logic irq_n
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (clr)  flag_q <= 1'b0;
      else if (set)  flag_q <= 1'b1;
   end

   always_comb begin
      status = flag_q;
      irq_n  = ~(flag_q & en);
   end

   // R6
   clr_drops_chk : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !status);

   // R6
   sticky_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (status && !clr) |=> status);
endmodule

// File: rtl/window_irq_persist.sv
module window_irq_persist #(
   parameter int DATA_W    = 16,
   parameter int CODE_W    = 4,
   parameter int LIN_CODES = 3,
   parameter int STEP_SZ   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_vld,
   input  logic [DATA_W-1:0] res_cnt,
   input  logic [DATA_W-1:0] lim_lo,
   input  logic [DATA_W-1:0] lim_hi,
   input  logic [CODE_W-1:0] pers_code,
   input  logic              irq_en,
   input  logic              irq_clr,
   output logic              irq_status,
   output logic              irq_n
);
   logic outside;
   logic fire;

   window_cmp #(.DATA_W(DATA_W)) cmp_i (
      .value  (res_cnt),
      .lo     (lim_lo),
      .hi     (lim_hi),
      .outside(outside)
   );

   persist_ctr #(
      .CODE_W   (CODE_W),
      .LIN_CODES(LIN_CODES),
      .STEP_SZ  (STEP_SZ)
   ) ctr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .res_vld(res_vld),
      .outside(outside),
      .clr    (irq_clr),
      .code   (pers_code),
      .fire   (fire)
   );

   irq_latch lat_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (fire),
      .clr   (irq_clr),
      .en    (irq_en),
      .status(irq_status),
      .irq_n (irq_n)
   );

   // R8
   rise_needs_vld_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status) |-> $past(res_vld));

   // R7
   masked_line_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> irq_n);

   // R2
   code0_fires_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !irq_clr && pers_code == '0) |=> irq_status);
endmodule

// File: tb/window_irq_persist_tb_top.sv
module window_irq_persist_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_vld = 1'b0;
   logic [15:0] res_cnt = '0;
   logic [15:0] lim_lo = 16'd100;
   logic [15:0] lim_hi = 16'd200;
   logic [3:0]  pers_code = '0;
   logic        irq_en = 1'b1;
   logic        irq_clr = 1'b0;
   logic        irq_status, irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   window_irq_persist dut_i (
      .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_cnt(res_cnt),
      .lim_lo(lim_lo), .lim_hi(lim_hi), .pers_code(pers_code),
      .irq_en(irq_en), .irq_clr(irq_clr),
      .irq_status(irq_status), .irq_n(irq_n)
   );

   function automatic int exp_len(int c);
      case (c)
         0: return 0;   1: return 1;   2: return 2;   3: return 3;
         4: return 5;   5: return 10;  6: return 15;  7: return 20;
         8: return 25;  9: return 30; 10: return 35; 11: return 40;
        12: return 45; 13: return 50; 14: return 55; default: return 60;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one cycle, then sample after the edge.
   task automatic step(bit v, logic [15:0] d, bit c);
      @(negedge clk);
      res_vld = v; res_cnt = d; irq_clr = c;
      @(posedge clk);
      #1;
      @(negedge clk);
      res_vld = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic do_clear();
      step(1'b0, 16'd0, 1'b1);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10
      chk("R10 status", int'(irq_status), 0);
      chk("R10 irq_n", int'(irq_n), 1);
      @(negedge clk) rst_n = 1'b1;

      // R1 window edges, code 1
      pers_code = 4'd1;
      begin
         int vals[14] = '{0, 1, 98, 99, 100, 101, 150, 199, 200, 201, 202,
                          1000, 65534, 65535};
         foreach (vals[i]) begin
            do_clear();
            step(1'b1, 16'(vals[i]), 1'b0);
            chk("R1 window", int'(irq_status),
                (vals[i] < 100 || vals[i] > 200) ? 1 : 0);
         end
      end

      // R2 code 0 fires on an inside value
      pers_code = 4'd0;
      do_clear();
      step(1'b1, 16'd150, 1'b0);
      chk("R2 code0 inside", int'(irq_status), 1);
      do_clear();
      step(1'b1, 16'd5, 1'b0);
      chk("R2 code0 outside", int'(irq_status), 1);

      // R3/R4/R5 sweep of every nonzero code
      for (int c = 1; c < 16; c++) begin
         int n;
         n = exp_len(c);
         pers_code = 4'(c);
         do_clear();
         for (int k = 0; k < n - 1; k++) step(1'b1, 16'd300, 1'b0);
         chk(c < 4 ? "R3 short" : "R4 short", int'(irq_status), 0);
         step(1'b1, 16'd150, 1'b0);           // R5 inside resets run
         for (int k = 0; k < n - 1; k++) step(1'b1, 16'd10, 1'b0);
         chk("R5 after reset run", int'(irq_status), 0);
         step(1'b1, 16'd10, 1'b0);
         chk(c < 4 ? "R3 exact" : "R4 exact", int'(irq_status), 1);
      end

      // R11 long stream keeps flag, R6 sticky over inside results
      pers_code = 4'd15;
      for (int k = 0; k < 130; k++) step(1'b1, 16'd900, 1'b0);
      chk("R11 saturate", int'(irq_status), 1);
      step(1'b1, 16'd150, 1'b0);
      step(1'b0, 16'd0, 1'b0);
      chk("R6 sticky", int'(irq_status), 1);

      // R7 enable mask
      irq_en = 1'b0; #1;
      chk("R7 masked line", int'(irq_n), 1);
      chk("R7 status kept", int'(irq_status), 1);
      irq_en = 1'b1; #1;
      chk("R7 line low", int'(irq_n), 0);
      do_clear();
      chk("R6 cleared", int'(irq_status), 0);
      chk("R7 line released", int'(irq_n), 1);

      // R8 no strobe, no effect
      pers_code = 4'd1;
      step(1'b0, 16'd5, 1'b0);
      chk("R8 no strobe", int'(irq_status), 0);
      pers_code = 4'd2;
      step(1'b1, 16'd5, 1'b0);
      step(1'b0, 16'd5, 1'b0);
      chk("R8 run held", int'(irq_status), 0);
      step(1'b1, 16'd5, 1'b0);
      chk("R8 run resumes", int'(irq_status), 1);

      // R9 clear beats qualifying result; run restarts
      do_clear();
      step(1'b1, 16'd5, 1'b0);
      step(1'b1, 16'd5, 1'b1);
      chk("R9 clear wins", int'(irq_status), 0);
      step(1'b1, 16'd5, 1'b0);
      chk("R9 restart one", int'(irq_status), 0);
      step(1'b1, 16'd5, 1'b0);
      chk("R9 restart two", int'(irq_status), 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule